// File: doc/BRIEF.md
# Resize Ratio Calculator

This block turns a pair of image dimensions per axis (source size and target size) into the configuration word that a two-stage hardware scaler consumes. For each axis it first decides how many times, at most twice, the source should be halved before fine resizing. It then computes the fractional step that the fine resizer advances per output pixel, with 13 fraction bits and a 14-bit field. The vertical and horizontal results are packed into one 32-bit word.

A request is made by pulsing `start_i` while the block is idle, with all four sizes on the inputs. The sizes are captured on that edge. The block checks each axis for ratios it cannot serve and flags them. It runs one restoring division per axis, one quotient bit per cycle, and signals completion with a single-cycle `done_o`. When either axis is rejected, `err_o` rises together with `done_o` and the previous configuration word is kept.

Top module: `rsz_ratio_calc`

## Requirements
- R1: An axis is rejected when its source size is 0 or above 4096, or its target size is below 2 or above 1024.
- R2: An axis is rejected when four times its target size is less than its source size; a ratio of exactly 4:1 is accepted.
- R3: The working size starts at the source size. It is halved with truncation while it is above 1024 or at least twice the target size, at most two times. The number of halvings is the axis downsize count.
- R4: The axis step equals floor(8192 × (working size − 1) / (target size − 1)).
- R5: A step of 16384 or more is replaced by 0x3FFF.
- R6: On success the word `cfg_o` holds vertical downsize count in bits [31:30], vertical step in [29:16], horizontal downsize count in [15:14] and horizontal step in [13:0].
- R7: The vertical axis is evaluated before the horizontal one. A rejection on either axis leaves `cfg_o` unchanged. A vertical rejection shows `done_o` 1 cycle after the start edge; a horizontal rejection shows it after 29 cycles.
- R8: `done_o` is high for exactly one cycle per accepted request, 56 cycles after the start edge on success. `err_o` is high only in that cycle, and only for a rejection. `busy_o` is high from the start edge until the edge that raises `done_o`.
- R9: `start_i` is ignored while `busy_o` is high. Size inputs that change after the start edge do not affect the running request.
- R10: After reset `cfg_o` is 0 and `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| in_w_i | input | 13 | Source width |
| in_h_i | input | 13 | Source height |
| out_w_i | input | 11 | Target width |
| out_h_i | input | 11 | Target height |
| busy_o | output | 1 | A request is being worked on |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| cfg_o | output | 32 | Packed scaler configuration word |

## Verification
The bench targets several boundaries:
- The exact 4:1 ratio, where a design using the wrong comparison would reject a legal request.
- A source above 1024 with a generous target, which exercises the halving rule that is driven by size alone rather than by ratio.
- Ratios just under 2:1 with tiny targets, where the quotient reaches 16384 and a design without saturation would wrap the field to a small value.

Rejections are placed on each axis separately. A design that evaluates the axes in the wrong order would show the wrong latency, and one that writes partial results would corrupt the held word. Requests that arrive while the block is busy, with changed sizes, would show up as a wrong word or a moved completion pulse in a design that fails to ignore them.

// File: rtl/rsz_pkg.sv
`timescale 1ns/1ps
package rsz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2
  } rsz_state_e;

  localparam logic AX_VERT = 1'b0;
  localparam logic AX_HORZ = 1'b1;

endpackage

// File: rtl/rsz_axis_check.sv
`timescale 1ns/1ps
module rsz_axis_check #(
  parameter int IN_W       = 13,
  parameter int OUT_W      = 11,
  parameter int MAX_IN     = 4096,
  parameter int MAX_OUT    = 1024,
  parameter int RATIO_LOG2 = 2
) (
  input  logic [IN_W-1:0]  in_sz,
  input  logic [OUT_W-1:0] out_sz,
  output logic             bad
);
  localparam int CW = ((IN_W > OUT_W + RATIO_LOG2) ? IN_W : (OUT_W + RATIO_LOG2)) + 1;

  logic [CW-1:0] in_x;
  logic [CW-1:0] out_x;
  logic [CW-1:0] out_scaled;
  logic          range_bad;
  logic          ratio_bad;

  assign in_x       = CW'(in_sz);
  assign out_x      = CW'(out_sz);
  assign out_scaled = out_x << RATIO_LOG2;

  // R1: size limits, plus zero source and unit target
  assign range_bad = (in_x > CW'(MAX_IN)) || (out_x > CW'(MAX_OUT)) ||
                     (in_x == '0) || (out_x < CW'(2));
  // R2: reduction steeper than the supported ratio
  assign ratio_bad = out_scaled < in_x;
  assign bad       = range_bad | ratio_bad;

endmodule

// File: rtl/rsz_halver.sv
`timescale 1ns/1ps
module rsz_halver #(
  parameter int IN_W       = 13,
  parameter int OUT_W      = 11,
  parameter int HALF_LIMIT = 1024,
  parameter int MAX_HALV   = 2,
  parameter int DS_W       = 2
) (
  input  logic [IN_W-1:0]  in_sz,
  input  logic [OUT_W-1:0] out_sz,
  output logic [DS_W-1:0]  ds_cnt,
  output logic [IN_W-1:0]  work_sz
);
  localparam int CW = ((IN_W > OUT_W + 1) ? IN_W : (OUT_W + 1)) + 1;

  logic [MAX_HALV:0][IN_W-1:0] w_st;
  logic [MAX_HALV:0][DS_W-1:0] d_st;
  logic [MAX_HALV:0]           live_st;
  logic [CW-1:0]               out_dbl;

  assign out_dbl    = CW'(out_sz) << 1;
  assign w_st[0]    = in_sz;
  assign d_st[0]    = '0;
  assign live_st[0] = 1'b1;

  // R3: one stage per permitted halving; once a stage declines, all later ones do
  for (genvar gi = 0; gi < MAX_HALV; gi++) begin : g_stage
    logic go;
    assign go = live_st[gi] &&
                ((CW'(w_st[gi]) > CW'(HALF_LIMIT)) || (CW'(w_st[gi]) >= out_dbl));
    assign w_st[gi+1]    = go ? (w_st[gi] >> 1) : w_st[gi];
    assign d_st[gi+1]    = d_st[gi] + DS_W'(go);
    assign live_st[gi+1] = go;
  end

  assign ds_cnt  = d_st[MAX_HALV];
  assign work_sz = w_st[MAX_HALV];

endmodule

// File: rtl/rsz_divider.sv
`timescale 1ns/1ps
module rsz_divider #(
  parameter int DVD_W = 26,
  parameter int DSR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic [DVD_W-1:0] quot_o,
  output logic             vld_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q;
  logic [DSR_W-1:0] rem_q;
  logic [DSR_W-1:0] dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             vld_q;

  logic [DSR_W:0]   trial;
  logic [DSR_W:0]   diff;
  logic             fits;
  logic [DSR_W-1:0] rem_nx;

  // restoring step: shift in next dividend bit, subtract when it fits
  always_comb begin
    trial  = {rem_q, quo_q[DVD_W-1]};
    fits   = trial >= {1'b0, dsr_q};
    diff   = trial - {1'b0, dsr_q};
    rem_nx = fits ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (load_i) begin
      quo_q <= dividend_i;
      rem_q <= '0;
      dsr_q <= divisor_i;
      cnt_q <= CNT_W'(DVD_W);
      run_q <= 1'b1;
      vld_q <= 1'b0;
    end else if (run_q) begin
      quo_q <= {quo_q[DVD_W-2:0], fits};
      rem_q <= rem_nx;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
        vld_q <= 1'b1;
      end
    end else begin
      vld_q <= 1'b0;
    end
  end

  assign quot_o = quo_q;
  assign vld_o  = vld_q;

  // R4
  rem_lt_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (rem_q < dsr_q));

  // R4
  step_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && fits) |-> !diff[DSR_W]);

endmodule

// File: rtl/rsz_ratio_calc.sv
`timescale 1ns/1ps
module rsz_ratio_calc #(
  parameter int IN_W       = 13,
  parameter int OUT_W      = 11,
  parameter int MAX_IN     = 4096,
  parameter int MAX_OUT    = 1024,
  parameter int HALF_LIMIT = 1024,
  parameter int MAX_HALV   = 2,
  parameter int RATIO_LOG2 = 2,
  parameter int FRAC_W     = 13,
  parameter int COEF_W     = 14,
  parameter int DS_W       = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic [IN_W-1:0]                 in_w_i,
  input  logic [IN_W-1:0]                 in_h_i,
  input  logic [OUT_W-1:0]                out_w_i,
  input  logic [OUT_W-1:0]                out_h_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            err_o,
  output logic [2*(DS_W+COEF_W)-1:0]      cfg_o
);
  import rsz_pkg::*;

  localparam int DVD_W  = IN_W + FRAC_W;
  localparam int AXIS_W = DS_W + COEF_W;
  localparam int WORD_W = 2 * AXIS_W;

  // R5: clamp the quotient into the step field
  function automatic logic [COEF_W-1:0] clamp_step(input logic [DVD_W-1:0] q);
    if (|q[DVD_W-1:COEF_W]) return '1;
    return q[COEF_W-1:0];
  endfunction

  // R6: vertical half on top, horizontal half below
  function automatic logic [WORD_W-1:0] pack_cfg(input logic [DS_W-1:0]   dv,
                                                 input logic [COEF_W-1:0] cv,
                                                 input logic [DS_W-1:0]   dh,
                                                 input logic [COEF_W-1:0] ch);
    return {dv, cv, dh, ch};
  endfunction

  rsz_state_e         state_q;
  logic               axis_q;
  logic [IN_W-1:0]    ih_q, iw_q;
  logic [OUT_W-1:0]   oh_q, ow_q;
  logic [DS_W-1:0]    dsv_q;
  logic [COEF_W-1:0]  stv_q;
  logic [WORD_W-1:0]  cfg_q;
  logic               done_q, err_q;

  logic [IN_W-1:0]    cur_in;
  logic [OUT_W-1:0]   cur_out;
  logic               axis_bad;
  logic [DS_W-1:0]    ds_c;
  logic [IN_W-1:0]    work_c;
  logic [DVD_W-1:0]   dividend;
  logic [OUT_W-1:0]   divisor;
  logic [DVD_W-1:0]   quot;
  logic               div_vld;

  // named internal events
  logic ev_accept, ev_fail, ev_load, ev_vdone, ev_finish;

  assign cur_in  = (axis_q == AX_HORZ) ? iw_q : ih_q;
  assign cur_out = (axis_q == AX_HORZ) ? ow_q : oh_q;

  rsz_axis_check #(
    .IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT),
    .RATIO_LOG2(RATIO_LOG2)
  ) i_check (
    .in_sz(cur_in), .out_sz(cur_out), .bad(axis_bad)
  );

  rsz_halver #(
    .IN_W(IN_W), .OUT_W(OUT_W), .HALF_LIMIT(HALF_LIMIT),
    .MAX_HALV(MAX_HALV), .DS_W(DS_W)
  ) i_halver (
    .in_sz(cur_in), .out_sz(cur_out), .ds_cnt(ds_c), .work_sz(work_c)
  );

  // R4: (work - 1) scaled by 2^FRAC_W over (target - 1)
  assign dividend = {work_c - IN_W'(1), FRAC_W'(0)};
  assign divisor  = cur_out - OUT_W'(1);

  assign ev_accept = (state_q == ST_IDLE) && start_i;
  assign ev_fail   = (state_q == ST_PREP) && axis_bad;
  assign ev_load   = (state_q == ST_PREP) && !axis_bad;
  assign ev_vdone  = (state_q == ST_DIV) && div_vld && (axis_q == AX_VERT);
  assign ev_finish = (state_q == ST_DIV) && div_vld && (axis_q == AX_HORZ);

  rsz_divider #(.DVD_W(DVD_W), .DSR_W(OUT_W)) i_div (
    .clk(clk), .rst_n(rst_n), .load_i(ev_load),
    .dividend_i(dividend), .divisor_i(divisor),
    .quot_o(quot), .vld_o(div_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      axis_q  <= AX_VERT;
      ih_q    <= '0;
      iw_q    <= '0;
      oh_q    <= '0;
      ow_q    <= '0;
      dsv_q   <= '0;
      stv_q   <= '0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (ev_accept) begin
        // R9: sizes captured once, at the start edge
        ih_q    <= in_h_i;
        iw_q    <= in_w_i;
        oh_q    <= out_h_i;
        ow_q    <= out_w_i;
        axis_q  <= AX_VERT;
        state_q <= ST_PREP;
      end
      if (ev_fail) begin
        // R7: abort with the held word untouched
        done_q  <= 1'b1;
        err_q   <= 1'b1;
        state_q <= ST_IDLE;
      end
      if (ev_load) state_q <= ST_DIV;
      if (ev_vdone) begin
        dsv_q   <= ds_c;
        stv_q   <= clamp_step(quot);
        axis_q  <= AX_HORZ;
        state_q <= ST_PREP;
      end
      if (ev_finish) begin
        cfg_q   <= pack_cfg(dsv_q, stv_q, ds_c, clamp_step(quot));
        done_q  <= 1'b1;
        state_q <= ST_IDLE;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign cfg_o  = cfg_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> (done_o && !err_o));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !ev_fail && !ev_finish) |=> busy_o);

  // R3
  halv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vdone || ev_finish) |-> (ds_c <= DS_W'(MAX_HALV)));

endmodule

// File: tb/test_rsz_ratio_calc.sv
`timescale 1ns/1ps
module test_rsz_ratio_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] in_w = '0, in_h = '0;
  logic [10:0] out_w = '0, out_h = '0;
  logic        busy, done, err;
  logic [31:0] cfg;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] exp_cfg = '0;

  always #2.5 clk = ~clk;

  rsz_ratio_calc i_rsz_ratio_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .in_w_i(in_w), .in_h_i(in_h), .out_w_i(out_w), .out_h_i(out_h),
    .busy_o(busy), .done_o(done), .err_o(err), .cfg_o(cfg)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired: actual cycles=%0d expected below 20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // behavioural model of one axis (R1, R2, R3, R4, R5)
  function automatic void ref_axis(input int si, input int so,
                                   output bit bad, output int ds, output int st);
    int  w;
    longint q;
    ds = 0; st = 0;
    bad = (si > 4096) || (so > 1024) || (si == 0) || (so < 2) || (so * 4 < si);
    if (bad) return;
    w = si;
    while (((w > 1024) || (w >= 2 * so)) && (ds < 2)) begin
      w = w / 2;
      ds++;
    end
    q = (longint'(8192) * longint'(w - 1)) / longint'(so - 1);
    st = (q >= 16384) ? 16383 : int'(q);
  endfunction

  task automatic run_case(input string tag, input int ih, input int iw,
                          input int oh, input int ow, input bit poke);
    bit bv, bh, e;
    int dv, sv, dh, sh, lat;
    logic [31:0] new_cfg;
    ref_axis(ih, oh, bv, dv, sv);
    ref_axis(iw, ow, bh, dh, sh);
    if (bv)      begin lat = 1;  e = 1'b1; end
    else if (bh) begin lat = 29; e = 1'b1; end
    else         begin lat = 56; e = 1'b0; end
    new_cfg = e ? exp_cfg : {2'(dv), 14'(sv), 2'(dh), 14'(sh)};
    in_h = 13'(ih); in_w = 13'(iw); out_h = 11'(oh); out_w = 11'(ow);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int n = 1; n <= lat + 1; n++) begin
      if (poke && n == 5) begin
        // R9: new request with other sizes while busy
        start = 1'b1;
        in_h = 13'd9; in_w = 13'd50; out_h = 11'd3; out_w = 11'd20;
      end
      if (poke && n == 6) start = 1'b0;
      @(posedge clk); #1;
      checks++;
      if (done !== (n == lat) || err !== ((n == lat) && e) ||
          busy !== (n < lat) || cfg !== ((n >= lat) ? new_cfg : exp_cfg)) begin
        failures++;
        $display("FAIL %s/R8 cyc %0d done=%b/%b err=%b/%b busy=%b/%b cfg=%h/%h",
                 tag, n, done, (n == lat), err, ((n == lat) && e),
                 busy, (n < lat), cfg, ((n >= lat) ? new_cfg : exp_cfg));
      end
    end
    exp_cfg = new_cfg;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (cfg !== 32'h0 || busy !== 1'b0 || done !== 1'b0 || err !== 1'b0) begin
      failures++;
      $display("FAIL R10 in reset cfg=%h/0 busy=%b/0 done=%b/0 err=%b/0", cfg, busy, done, err);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (cfg !== 32'h0 || busy !== 1'b0 || done !== 1'b0 || err !== 1'b0) begin
      failures++;
      $display("FAIL R10 after reset cfg=%h/0 busy=%b/0 done=%b/0 err=%b/0", cfg, busy, done, err);
    end

    run_case("R4", 480, 640, 240, 320, 1'b0);   // 2:1 both axes
    run_case("R3", 2000, 4096, 1024, 1024, 1'b0); // size-driven halving, two halvings
    run_case("R5", 3, 7, 2, 2, 1'b0);           // saturation, with and without halving
    run_case("R4", 100, 17, 1000, 1024, 1'b0);  // upscaling
    run_case("R6", 1023, 1500, 1000, 700, 1'b0);
    run_case("R2", 400, 4000, 100, 1000, 1'b0); // exact 4:1 accepted
    run_case("R9", 720, 1280, 480, 800, 1'b1);  // start while busy ignored
    run_case("R1", 4097, 640, 1024, 320, 1'b0); // vertical source too large
    run_case("R7", 480, 640, 240, 1025, 1'b0);  // horizontal target too large
    run_case("R1", 480, 640, 1, 320, 1'b0);     // unit target
    run_case("R1", 480, 0, 240, 320, 1'b0);     // zero source
    run_case("R2", 401, 640, 100, 320, 1'b0);   // vertical ratio too steep
    run_case("R7", 480, 401, 240, 100, 1'b0);   // horizontal ratio too steep
    run_case("R6", 64, 33, 64, 33, 1'b0);       // unity after rejects

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule